// File: doc/BRIEF.md
# Snooping Write-Back Coherence Controller

This block keeps the coherence state of a small direct-mapped, write-back cache that sits on a shared snooping bus. Each line holds a tag and one of three states: Invalid, Shared (clean, read-only) or Exclusive (dirty, writable). The controller checks local processor reads and writes against the line that the address maps to. It decides whether the access completes at once or needs the bus, and it issues the needed bus transaction once the arbiter grants the bus. The transaction is a read miss, a write miss or a write-back of a dirty victim.

At the same time it watches the read misses and write misses that other agents put on the bus. A snooped miss that hits a valid line here changes that line's state. When the line is Exclusive, the controller answers at once with a write-back of the dirty block and raises an abort flag, so that main memory does not answer the other agent. Snoop answers go out in the same cycle as the snooped miss and do not wait for a grant. A local request that meets a matching snoop waits one cycle.

Addresses are block addresses. The low `IDX_W` bits select the line and the rest form the tag. Bus commands use the code none = 0, read miss = 1, write miss = 2 and write-back = 3.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. With no request and no snoop, `bus_valid`, `bus_abort`, `cpu_busy` and `cpu_hit` are all 0.
- R2: A read whose line is Invalid, or Shared with a different tag, drives `bus_cmd`=1 at the request address in a cycle where `bus_grant` is 1. In that cycle `cpu_busy` is 0, and the line becomes Shared with the new tag.
- R3: A write whose line is Invalid, or Shared with any tag (hit or miss), drives `bus_cmd`=2 at the request address when granted. In that cycle `cpu_busy` is 0, and the line becomes Exclusive with the new tag.
- R4: A read that hits a Shared or Exclusive line, and a write that hits an Exclusive line, finish in the cycle they appear. In that cycle `cpu_hit`=1, `cpu_busy`=0 and no bus transaction occurs.
- R5: An access whose line is Exclusive with a different tag first drives a write-back (`bus_cmd`=3, `bus_abort`=0) of the old block address {old tag, index} when granted. It leaves the line Invalid and keeps `cpu_busy` at 1. The miss of R2 or R3 follows on a later granted cycle.
- R6: While a request needs the bus and `bus_grant` is 0, `cpu_busy` stays 1 and no local transaction is driven.
- R7: A snooped write miss (`snp_cmd`=2) that matches a valid line makes the line Invalid. If the line was Exclusive, the same cycle carries a write-back of the snooped address with `bus_abort`=1. From Shared, no bus transaction occurs.
- R8: A snooped read miss (`snp_cmd`=1) that matches an Exclusive line drives a write-back of the snooped address with `bus_abort`=1 and makes the line Shared. A match on a Shared line changes nothing.
- R9: A snoop whose address matches no valid line, or whose `snp_cmd` is 0 or 3, has no effect on the bus or on any line.
- R10: In a cycle where a snoop matches a valid line, the local request does not complete and issues nothing, even with `bus_grant`=1. `cpu_busy` is 1 whenever a request is present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor access present (held while busy) |
| cpu_req_write | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | ADDR_W | Block address of the access |
| cpu_busy | output | 1 | Access not finished this cycle |
| cpu_hit | output | 1 | Access address matches a valid line |
| bus_grant | input | 1 | Arbiter grants the bus to local requests |
| bus_valid | output | 1 | A transaction is driven this cycle |
| bus_cmd | output | 2 | Transaction code (1 read miss, 2 write miss, 3 write-back) |
| bus_addr | output | ADDR_W | Block address of the transaction |
| bus_abort | output | 1 | Memory must not answer; this cache supplies the block |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | Code of the snooped transaction |
| snp_addr | input | ADDR_W | Block address of the snooped transaction |

## Verification
Line state can only be seen through the ports, so a wrong state or tag shows up at the next access or snoop that reaches that line. A line left Exclusive by mistake shows as a spurious aborting write-back on a snoop, or as a write that hits with no bus traffic. A line wrongly left valid shows as a false `cpu_hit`, and a line wrongly dropped shows as an extra miss. The bench therefore follows every state change with a request or snoop to the same line within a few cycles. It compares the bus and handshake outputs against a behavioural model on every cycle, so a divergence is reported in the first cycle where it reaches a port.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_NONE   = 2'd0,
    BUS_RDMISS = 2'd1,
    BUS_WRMISS = 2'd2,
    BUS_WRBACK = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_st,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_st,
  output logic [TAG_W-1:0] b_tag
);
  line_st_e         st_all  [LINES];
  logic [TAG_W-1:0] tag_all [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    line_st_e         st_r;
    logic [TAG_W-1:0] tag_r;
    logic             line_we;

    assign line_we = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= LN_INV;
        tag_r <= '0;
      end else if (line_we) begin
        st_r  <= wr_st;
        tag_r <= wr_tag;
      end
    end

    assign st_all[i]  = st_r;
    assign tag_all[i] = tag_r;

    // R1: a line only ever holds one of the three legal states
    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      st_r != line_st_e'(2'b11));
  end

  assign a_st  = st_all[a_idx];
  assign a_tag = tag_all[a_idx];
  assign b_st  = st_all[b_idx];
  assign b_tag = tag_all[b_idx];
endmodule

// File: rtl/coh_local_req.sv
module coh_local_req
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic              stall,
  input  logic              bus_grant,
  output logic              hit,
  output logic              done,
  output logic              issue,
  output bus_cmd_e          cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              upd_en,
  output line_st_e          upd_st,
  output logic [TAG_W-1:0]  upd_tag
);
  logic [IDX_W-1:0] ridx;
  logic [TAG_W-1:0] rtag;
  logic             tag_eq;
  logic             want;

  assign ridx   = req_addr[IDX_W-1:0];
  assign rtag   = req_addr[ADDR_W-1:IDX_W];
  assign tag_eq = (ln_tag == rtag);
  assign hit    = req_valid && (ln_st != LN_INV) && tag_eq;
  assign issue  = want && bus_grant;

  always_comb begin
    done    = 1'b0;
    want    = 1'b0;
    cmd     = BUS_NONE;
    addr    = '0;
    upd_en  = 1'b0;
    upd_st  = LN_INV;
    upd_tag = rtag;
    if (req_valid && !stall) begin
      if (hit && (!req_write || ln_st == LN_EXC)) begin
        done = 1'b1;
      end else begin
        want   = 1'b1;
        upd_en = bus_grant;
        if (ln_st == LN_EXC && !tag_eq) begin
          // dirty victim leaves first; the line passes through Invalid
          cmd     = BUS_WRBACK;
          addr    = {ln_tag, ridx};
          upd_st  = LN_INV;
          upd_tag = ln_tag;
        end else begin
          addr = req_addr;
          done = bus_grant;
          if (req_write) begin
            cmd    = BUS_WRMISS;
            upd_st = LN_EXC;
          end else begin
            cmd    = BUS_RDMISS;
            upd_st = LN_SHR;
          end
        end
      end
    end
  end
endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  output logic              hit,
  output logic              resp,
  output logic              upd_en,
  output line_st_e          upd_st
);
  logic is_rd;
  logic is_wr;

  assign is_rd = (snp_cmd == BUS_RDMISS);
  assign is_wr = (snp_cmd == BUS_WRMISS);
  assign hit   = snp_valid && (is_rd || is_wr) && (ln_st != LN_INV)
              && (ln_tag == snp_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    resp   = 1'b0;
    upd_en = 1'b0;
    upd_st = ln_st;
    if (hit) begin
      if (is_wr) begin
        resp   = (ln_st == LN_EXC);
        upd_en = 1'b1;
        upd_st = LN_INV;
      end else if (ln_st == LN_EXC) begin
        resp   = 1'b1;
        upd_en = 1'b1;
        upd_st = LN_SHR;
      end
    end
  end
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_busy,
  output logic              cpu_hit,
  input  logic              bus_grant,
  output logic              bus_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_abort,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr
);
  line_st_e         a_st, b_st, lc_st, sn_st, wr_st;
  logic [TAG_W-1:0] a_tag, b_tag, lc_tag, wr_tag;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;
  logic             sn_hit, sn_resp, sn_upd;
  logic             lc_done, lc_issue, lc_upd;
  bus_cmd_e         lc_cmd;
  logic [ADDR_W-1:0] lc_addr;

  coh_line_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk, .rst_n,
    .wr_en, .wr_idx, .wr_tag, .wr_st,
    .a_idx(cpu_req_addr[IDX_W-1:0]), .a_st, .a_tag,
    .b_idx(snp_addr[IDX_W-1:0]),     .b_st, .b_tag
  );

  coh_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop (
    .snp_valid, .snp_cmd, .snp_addr,
    .ln_st(b_st), .ln_tag(b_tag),
    .hit(sn_hit), .resp(sn_resp), .upd_en(sn_upd), .upd_st(sn_st)
  );

  coh_local_req #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_local (
    .req_valid(cpu_req_valid), .req_write(cpu_req_write), .req_addr(cpu_req_addr),
    .ln_st(a_st), .ln_tag(a_tag),
    .stall(sn_hit), .bus_grant,
    .hit(cpu_hit), .done(lc_done), .issue(lc_issue),
    .cmd(lc_cmd), .addr(lc_addr),
    .upd_en(lc_upd), .upd_st(lc_st), .upd_tag(lc_tag)
  );

  // single update port: a matching snoop stalls the local side, so at most one writes
  always_comb begin
    wr_en = sn_upd || lc_upd;
    if (sn_upd) begin
      wr_idx = snp_addr[IDX_W-1:0];
      wr_tag = b_tag;
      wr_st  = sn_st;
    end else begin
      wr_idx = cpu_req_addr[IDX_W-1:0];
      wr_tag = lc_tag;
      wr_st  = lc_st;
    end
  end

  // snoop answer wins the bus slot over a local transaction
  always_comb begin
    bus_valid = sn_resp || lc_issue;
    bus_abort = sn_resp;
    bus_cmd   = BUS_NONE;
    bus_addr  = '0;
    if (sn_resp) begin
      bus_cmd  = BUS_WRBACK;
      bus_addr = snp_addr;
    end else if (lc_issue) begin
      bus_cmd  = lc_cmd;
      bus_addr = lc_addr;
    end
  end

  assign cpu_busy = cpu_req_valid && !lc_done;

  // R6: a local transaction only goes out under grant
  p_local_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_abort) |-> bus_grant);

  // R7: the memory abort flag only rides on a write-back
  p_abort_on_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |-> (bus_valid && bus_cmd == BUS_WRBACK));

  // R5: a victim write-back never completes the access
  p_victim_keeps_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_abort && bus_cmd == BUS_WRBACK) |-> cpu_busy);

  // R10: a matching snoop holds off any present request
  p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sn_hit && cpu_req_valid) |-> cpu_busy);

  // R4: a completed read hit uses no bus slot
  p_read_hit_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && !cpu_req_write && cpu_hit && !cpu_busy) |-> !bus_valid);
endmodule

// File: tb/snoop_coh_ctrl_bench.sv
module snoop_coh_ctrl_bench;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int LINES  = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic              cpu_busy, cpu_hit;
  logic              bus_grant = 1'b0;
  logic              bus_valid, bus_abort;
  logic [1:0]        bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic              snp_valid = 1'b0;
  logic [1:0]        snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model: 0 Invalid, 1 Shared, 2 Exclusive
  int mst  [LINES];
  int mtag [LINES];

  always #4 clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_snoop_coh_ctrl (.*);

  task automatic step(input bit rv, input bit wr, input int ra, input bit g,
                      input bit sv, input int sc, input int sa, input string force_lbl);
    int    ridx, rtag, sidx, stag, lst;
    bit    shit, resp, done, e_valid, e_abort, e_busy, e_hit, ok;
    int    e_cmd, e_addr;
    string lbl;
    @(negedge clk);
    cpu_req_valid = rv; cpu_req_write = wr; cpu_req_addr = ADDR_W'(ra);
    bus_grant = g; snp_valid = sv; snp_cmd = 2'(sc); snp_addr = ADDR_W'(sa);
    #1;
    ridx = ra % LINES; rtag = ra / LINES;
    sidx = sa % LINES; stag = sa / LINES;
    e_valid = 0; e_cmd = 0; e_addr = 0; e_abort = 0; done = 0; resp = 0;
    lbl = "R9";
    shit = sv && (sc == 1 || sc == 2) && mst[sidx] != 0 && mtag[sidx] == stag;
    lst = mst[ridx];
    e_hit = rv && lst != 0 && mtag[ridx] == rtag;
    if (shit) begin
      if (sc == 2) begin lbl = "R7"; resp = (mst[sidx] == 2); end
      else if (mst[sidx] == 2) begin lbl = "R8"; resp = 1; end
      else lbl = "R8";
      if (resp) begin e_valid = 1; e_cmd = 3; e_addr = sa; e_abort = 1; end
      if (rv) lbl = {lbl, "/R10"};
    end else if (rv) begin
      if (e_hit && (!wr || lst == 2)) begin done = 1; lbl = "R4"; end
      else if (!g) lbl = "R6";
      else if (lst == 2 && mtag[ridx] != rtag) begin
        lbl = "R5"; e_valid = 1; e_cmd = 3; e_addr = mtag[ridx] * LINES + ridx;
      end else begin
        done = 1; e_valid = 1; e_addr = ra;
        if (wr) begin lbl = "R3"; e_cmd = 2; end else begin lbl = "R2"; e_cmd = 1; end
      end
    end
    e_busy = rv && !done;
    if (force_lbl != "") lbl = force_lbl;
    ok = (bus_valid == e_valid) && (bus_abort == e_abort) && (cpu_busy == e_busy)
      && (cpu_hit == e_hit) && (!e_valid || (int'(bus_cmd) == e_cmd && int'(bus_addr) == e_addr));
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got valid=%0b cmd=%0d addr=%0h abort=%0b busy=%0b hit=%0b expected valid=%0b cmd=%0d addr=%0h abort=%0b busy=%0b hit=%0b",
               lbl, bus_valid, bus_cmd, bus_addr, bus_abort, cpu_busy, cpu_hit,
               e_valid, e_cmd, e_addr, e_abort, e_busy, e_hit);
    end
    // state update at the coming edge
    if (shit) begin
      if (sc == 2) mst[sidx] = 0;
      else if (mst[sidx] == 2) mst[sidx] = 1;
    end else if (rv && g && !done && lst == 2 && mtag[ridx] != rtag) begin
      mst[ridx] = 0;
    end else if (rv && g && done && !(e_hit && (!wr || lst == 2))) begin
      mst[ridx] = wr ? 2 : 1; mtag[ridx] = rtag;
    end
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin mst[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, and a first read misses
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 0, 'h10, 0, 0, 0, 0, "R1");
    step(1, 0, 'h10, 0, 0, 0, 0, "");     // R6 waits for grant
    step(1, 0, 'h10, 1, 0, 0, 0, "");     // R2 read miss
    step(1, 0, 'h10, 0, 0, 0, 0, "");     // R4 read hit in Shared
    step(1, 1, 'h10, 1, 0, 0, 0, "");     // R3 write hit on Shared
    step(1, 1, 'h10, 0, 0, 0, 0, "");     // R4 write hit Exclusive
    step(1, 0, 'h10, 0, 0, 0, 0, "");     // R4 read hit Exclusive
    step(0, 0, 0, 0, 1, 1, 'h10, "");     // R8 downgrade with abort
    step(0, 0, 0, 0, 1, 1, 'h10, "");     // R8 Shared unaffected
    step(1, 1, 'h10, 1, 0, 0, 0, "");     // R3 back to Exclusive
    step(0, 0, 0, 0, 1, 2, 'h20, "");     // R9 tag mismatch
    step(0, 0, 0, 0, 1, 3, 'h10, "");     // R9 write-back code ignored
    step(0, 0, 0, 0, 1, 0, 'h10, "");     // R9 code 0 ignored
    step(1, 0, 'h10, 0, 0, 0, 0, "R9");   // still Exclusive: read hit
    step(1, 0, 'h20, 0, 0, 0, 0, "");     // R6 dirty victim waiting
    step(1, 0, 'h20, 1, 0, 0, 0, "");     // R5 victim write-back
    step(1, 0, 'h20, 1, 0, 0, 0, "");     // R2 then the read miss
    step(1, 0, 'h10, 1, 0, 0, 0, "");     // R2 Shared, different tag
    step(0, 0, 0, 0, 1, 2, 'h10, "");     // R7 Shared -> Invalid, quiet
    step(1, 0, 'h10, 0, 0, 0, 0, "R7");   // misses now
    step(1, 1, 'h21, 1, 0, 0, 0, "");     // R3 from Invalid
    step(0, 0, 0, 0, 1, 2, 'h21, "");     // R7 Exclusive -> Invalid with abort
    step(1, 1, 'h21, 1, 0, 0, 0, "");     // R3 again
    step(1, 0, 'h10, 1, 0, 0, 0, "");     // R2 line0 Shared
    step(1, 1, 'h10, 1, 1, 1, 'h21, "");  // R10 snoop answer wins
    step(1, 1, 'h10, 1, 0, 0, 0, "");     // R3 proceeds next cycle
    step(1, 0, 'h10, 1, 1, 1, 'h10, "");  // R10 stall on same line
    // mixed traffic
    begin
      bit rv = 0, wr = 0;
      int ra = 0;
      int addrs [6] = '{'h10, 'h20, 'h11, 'h21, 'h13, 'h33};
      for (int n = 0; n < 600; n++) begin
        bit g, sv;
        int sc, sa;
        if (!cpu_busy) begin
          rv = ($urandom_range(0, 3) != 0);
          wr = $urandom_range(0, 1);
          ra = addrs[$urandom_range(0, 5)];
        end
        g  = $urandom_range(0, 1);
        sv = ($urandom_range(0, 3) == 0);
        sc = $urandom_range(0, 3);
        sa = addrs[$urandom_range(0, 5)];
        step(rv, wr, ra, g, sv, sc, sa, "");
      end
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got no end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule